// File: doc/BRIEF.md
# Serial EEPROM Image Checksum Loader

This block fills a local cache with the 64-word configuration image held in a serial EEPROM and decides whether that image can be trusted. It reads the words one at a time, in ascending address order, through a simple request/acknowledge port to a separate serial EEPROM master. Each word goes into a register array and into a running 16-bit sum. The image is accepted only when that wrapped sum equals 16'hBABA and a two-bit signature field in one initialization word holds the expected pattern. If the checksum fails, the block clears the signature field in the cache. That one field therefore carries the validity of the whole cached image.

Consumers fetch words by index. When the cached signature is already good, the answer comes straight from the cache and the EEPROM is not touched. When it is not, the block first reloads the whole image and then answers. An index past the end of the image, or an image that cannot be validated, returns zero. A second command recomputes the checksum word: it reads words 0 to 62, subtracts their sum from the target and writes the result to word 63. Because the block has just written the EEPROM, it drops the cached signature.

Top module: `eeprom_image_loader`

## Requirements
- R1: A load reads EEPROM words 0 through 63 in strictly ascending address order on `mem_addr_o`. One word transfers on each cycle with `mem_req_o` and `mem_ack_i` both high. Each word is stored in the cache at its own address.
- R2: The load adds every word into a 16-bit sum that wraps on overflow. The load passes only when this sum equals 16'hBABA and the signature check of R4 also succeeds.
- R3: When the sum differs from 16'hBABA, the load fails. Bits [15:14] of cached word 10 are cleared, `err_o` goes to 1 and `img_valid_o` goes to 0.
- R4: When the sum is correct but bits [15:14] of word 10 are not 2'b01, the load also fails with `err_o` at 1. `img_valid_o` equals (cached word 10 bits [15:14] == 2'b01) at all times.
- R5: `busy_o` is high from the cycle after an accepted command until the operation ends. `done_o` is a one-cycle pulse in the first cycle with `busy_o` low again, and `pass_o` is valid with it. A passing load clears `err_o`. After reset all outputs are 0.
- R6: A lookup with `img_valid_o` high and index below 64 answers in the next cycle: `lkp_vld_o` is 1 and `lkp_word_o` holds the cached word. No EEPROM transfer takes place.
- R7: A lookup with `img_valid_o` low and index below 64 runs a full load first. `lkp_vld_o` then pulses in the same cycle as `done_o`, with the cached word if the load passed and 0 if it failed.
- R8: A lookup with index 64 or more answers in the next cycle with `lkp_word_o` = 0. It starts no load and no EEPROM transfer.
- R9: An update command reads words 0 to 62 in ascending order. It then makes one write transfer (`mem_wr_o` = 1) to address 63 with data 16'hBABA minus the wrapped sum of those 63 words. It ends with `done_o` and `pass_o` both 1.
- R10: After any EEPROM write completes, `img_valid_o` is 0.
- R11: While `busy_o` is high, the load, update and lookup strobes are ignored. In the idle state, when strobes arrive together, load has priority over update, and update has priority over lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Strobe: load and validate the whole image |
| upd_i | input | 1 | Strobe: recompute and write the checksum word |
| lkp_req_i | input | 1 | Strobe: word lookup request |
| lkp_idx_i | input | 7 | Lookup index (values 64 and above are out of range) |
| lkp_vld_o | output | 1 | Lookup answer pulse |
| lkp_word_o | output | 16 | Lookup answer word |
| img_valid_o | output | 1 | Cached signature field holds the valid pattern |
| err_o | output | 1 | Last load failed its checksum or its signature check |
| busy_o | output | 1 | Load or update in progress |
| done_o | output | 1 | End-of-operation pulse |
| pass_o | output | 1 | Status of the operation, valid with done_o |
| mem_req_o | output | 1 | Transfer request toward the EEPROM master |
| mem_wr_o | output | 1 | Request is a write (1) or a read (0) |
| mem_addr_o | output | 6 | Word address of the transfer |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Transfer completes in this cycle |
| mem_rdata_i | input | 16 | Read data, valid with mem_ack_i |

## Verification
On every cycle, the assertions check four things: read addresses advance by exactly one, writes only ever target the checksum word, a failed load or a completed write leaves the image invalid, and invalid or out-of-range lookups answer zero. Other properties depend on whole images, and only the bench scenarios show them. These are that the 64-word wrapped sum decides pass or fail, that the written checksum has the right value, that valid lookups cause no EEPROM traffic, and that strobes arriving while busy are dropped. The bench sweeps many generated images with each signature pattern and with correct and wrong checksums, and computes the expected result arithmetically.

// File: rtl/eeimg_pkg.sv
package eeimg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_CHECK = 3'd2,
        ST_SUMRD = 3'd3,
        ST_WRCK  = 3'd4
    } eeimg_state_e;

endpackage

// File: rtl/eeimg_cache.sv
module eeimg_cache #(
    parameter int          WORDS    = 64,
    parameter int          DW       = 16,
    parameter int          AW       = 6,
    parameter int          SIG_WORD = 10,
    parameter int          SIG_LSB  = 14,
    parameter int          SIG_W    = 2,
    parameter logic [1:0]  SIG_OK   = 2'b01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          sig_clr,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          sig_ok
);

    logic [DW-1:0] mem_q [WORDS];

    // one register per image word, each with its own next-value logic
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DW-1:0] word_d;

        always_comb begin
            word_d = mem_q[g];
            if (wr_en && (wr_addr == AW'(g))) begin
                word_d = wr_data;
            end
            // a signature clear wins over a same-cycle write of that word
            if (sig_clr && (g == SIG_WORD)) begin
                word_d[SIG_LSB +: SIG_W] = '0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= word_d;
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
    assign sig_ok  = (mem_q[SIG_WORD][SIG_LSB +: SIG_W] == SIG_W'(SIG_OK));

endmodule

// File: rtl/eeimg_accum.sv
module eeimg_accum #(
    parameter int            DW     = 16,
    parameter logic [DW-1:0] TARGET = 16'hBABA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add_en,
    input  logic [DW-1:0] add_val,
    output logic          match_o,
    output logic [DW-1:0] comp_o
);

    logic [DW-1:0] sum_d, sum_q;
    logic [DW-1:0] sum_nxt;

    always_comb begin
        sum_nxt = sum_q + add_val;   // wraps modulo 2**DW
        sum_d   = sum_q;
        if (clr) begin
            sum_d = '0;
        end else if (add_en) begin
            sum_d = sum_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign match_o = (sum_q == TARGET);
    // checksum word that makes the sum including the current word hit TARGET
    assign comp_o  = TARGET - sum_nxt;

endmodule

// File: rtl/eeimg_ctrl.sv
module eeimg_ctrl
    import eeimg_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int DW    = 16,
    parameter int AW    = 6,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          upd_i,
    input  logic          lkp_req_i,
    input  logic [IW-1:0] lkp_idx_i,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          sum_match_i,
    input  logic [DW-1:0] comp_i,
    input  logic          sig_ok_i,
    input  logic [DW-1:0] cache_rd_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          pass_o,
    output logic          err_o,
    output logic          lkp_vld_o,
    output logic [DW-1:0] lkp_word_o,
    output logic          mem_req_o,
    output logic          mem_wr_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          cache_we_o,
    output logic [AW-1:0] cache_waddr_o,
    output logic [DW-1:0] cache_wdata_o,
    output logic          sig_clr_o,
    output logic [AW-1:0] cache_raddr_o,
    output logic          acc_clr_o,
    output logic          acc_add_o,
    output logic [DW-1:0] acc_val_o
);

    localparam logic [AW-1:0] LAST_WORD = AW'(WORDS - 1);
    localparam logic [AW-1:0] LAST_SUM  = AW'(WORDS - 2);
    localparam logic [IW-1:0] IDX_LIMIT = IW'(WORDS);

    typedef struct packed {
        eeimg_state_e  st;
        logic [AW-1:0] addr;
        logic [AW-1:0] idx;
        logic          pend;
        logic          err;
        logic          pass;
        logic          done;
        logic          lvld;
        logic [DW-1:0] lword;
        logic [DW-1:0] wdata;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  xfer;
    logic  img_ok;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.lvld  = 1'b0;

        mem_req_o     = (r_q.st == ST_LOAD) || (r_q.st == ST_SUMRD) || (r_q.st == ST_WRCK);
        mem_wr_o      = (r_q.st == ST_WRCK);
        mem_addr_o    = r_q.addr;
        mem_wdata_o   = r_q.wdata;
        xfer          = mem_req_o && mem_ack_i;
        img_ok        = sum_match_i && sig_ok_i;

        cache_we_o    = 1'b0;
        cache_waddr_o = r_q.addr;
        cache_wdata_o = mem_rdata_i;
        sig_clr_o     = 1'b0;
        cache_raddr_o = (r_q.st == ST_IDLE) ? lkp_idx_i[AW-1:0] : r_q.idx;
        acc_clr_o     = 1'b0;
        acc_add_o     = 1'b0;
        acc_val_o     = mem_rdata_i;

        unique case (r_q.st)
            ST_IDLE: begin
                if (load_i) begin
                    r_d.st    = ST_LOAD;
                    r_d.addr  = '0;
                    r_d.pend  = 1'b0;
                    acc_clr_o = 1'b1;
                end else if (upd_i) begin
                    r_d.st    = ST_SUMRD;
                    r_d.addr  = '0;
                    acc_clr_o = 1'b1;
                end else if (lkp_req_i) begin
                    if (lkp_idx_i >= IDX_LIMIT) begin
                        r_d.lvld  = 1'b1;
                        r_d.lword = '0;
                    end else if (sig_ok_i) begin
                        r_d.lvld  = 1'b1;
                        r_d.lword = cache_rd_i;
                    end else begin
                        r_d.st    = ST_LOAD;
                        r_d.addr  = '0;
                        r_d.pend  = 1'b1;
                        r_d.idx   = lkp_idx_i[AW-1:0];
                        acc_clr_o = 1'b1;
                    end
                end
            end

            ST_LOAD: begin
                if (xfer) begin
                    cache_we_o = 1'b1;
                    acc_add_o  = 1'b1;
                    if (r_q.addr == LAST_WORD) begin
                        r_d.st = ST_CHECK;
                    end else begin
                        r_d.addr = r_q.addr + AW'(1);
                    end
                end
            end

            ST_CHECK: begin
                sig_clr_o = !sum_match_i;
                r_d.err   = !img_ok;
                r_d.pass  = img_ok;
                r_d.done  = 1'b1;
                r_d.st    = ST_IDLE;
                if (r_q.pend) begin
                    r_d.lvld  = 1'b1;
                    r_d.lword = img_ok ? cache_rd_i : '0;
                    r_d.pend  = 1'b0;
                end
            end

            ST_SUMRD: begin
                if (xfer) begin
                    cache_we_o = 1'b1;
                    acc_add_o  = 1'b1;
                    if (r_q.addr == LAST_SUM) begin
                        r_d.wdata = comp_i;
                        r_d.addr  = LAST_WORD;
                        r_d.st    = ST_WRCK;
                    end else begin
                        r_d.addr = r_q.addr + AW'(1);
                    end
                end
            end

            ST_WRCK: begin
                if (xfer) begin
                    cache_we_o    = 1'b1;
                    cache_wdata_o = r_q.wdata;
                    sig_clr_o     = 1'b1;
                    r_d.pass      = 1'b1;
                    r_d.done      = 1'b1;
                    r_d.st        = ST_IDLE;
                end
            end

            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = r_q.done;
    assign pass_o     = r_q.pass;
    assign err_o      = r_q.err;
    assign lkp_vld_o  = r_q.lvld;
    assign lkp_word_o = r_q.lword;

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R5

    AST_WR_CKWORD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_wr_o) |-> (mem_addr_o == LAST_WORD)); // R9

endmodule

// File: rtl/eeprom_image_loader.sv
module eeprom_image_loader #(
    parameter int            WORDS    = 64,
    parameter int            DW       = 16,
    parameter logic [15:0]   TARGET   = 16'hBABA,
    parameter int            SIG_WORD = 10,
    parameter int            SIG_LSB  = 14,
    parameter int            SIG_W    = 2,
    parameter logic [1:0]    SIG_OK   = 2'b01,
    localparam int           AW       = $clog2(WORDS),
    localparam int           IW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          upd_i,
    input  logic          lkp_req_i,
    input  logic [IW-1:0] lkp_idx_i,
    output logic          lkp_vld_o,
    output logic [DW-1:0] lkp_word_o,
    output logic          img_valid_o,
    output logic          err_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          pass_o,
    output logic          mem_req_o,
    output logic          mem_wr_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] mem_rdata_i
);

    logic          cache_we;
    logic [AW-1:0] cache_waddr;
    logic [DW-1:0] cache_wdata;
    logic          sig_clr;
    logic [AW-1:0] cache_raddr;
    logic [DW-1:0] cache_rd;
    logic          sig_ok;
    logic          acc_clr;
    logic          acc_add;
    logic [DW-1:0] acc_val;
    logic          sum_match;
    logic [DW-1:0] comp;

    eeimg_cache #(
        .WORDS    (WORDS),
        .DW       (DW),
        .AW       (AW),
        .SIG_WORD (SIG_WORD),
        .SIG_LSB  (SIG_LSB),
        .SIG_W    (SIG_W),
        .SIG_OK   (SIG_OK)
    ) u_cache (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cache_we),
        .wr_addr (cache_waddr),
        .wr_data (cache_wdata),
        .sig_clr (sig_clr),
        .rd_addr (cache_raddr),
        .rd_data (cache_rd),
        .sig_ok  (sig_ok)
    );

    eeimg_accum #(
        .DW     (DW),
        .TARGET (DW'(TARGET))
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (acc_clr),
        .add_en  (acc_add),
        .add_val (acc_val),
        .match_o (sum_match),
        .comp_o  (comp)
    );

    eeimg_ctrl #(
        .WORDS (WORDS),
        .DW    (DW),
        .AW    (AW),
        .IW    (IW)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (load_i),
        .upd_i         (upd_i),
        .lkp_req_i     (lkp_req_i),
        .lkp_idx_i     (lkp_idx_i),
        .mem_ack_i     (mem_ack_i),
        .mem_rdata_i   (mem_rdata_i),
        .sum_match_i   (sum_match),
        .comp_i        (comp),
        .sig_ok_i      (sig_ok),
        .cache_rd_i    (cache_rd),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .pass_o        (pass_o),
        .err_o         (err_o),
        .lkp_vld_o     (lkp_vld_o),
        .lkp_word_o    (lkp_word_o),
        .mem_req_o     (mem_req_o),
        .mem_wr_o      (mem_wr_o),
        .mem_addr_o    (mem_addr_o),
        .mem_wdata_o   (mem_wdata_o),
        .cache_we_o    (cache_we),
        .cache_waddr_o (cache_waddr),
        .cache_wdata_o (cache_wdata),
        .sig_clr_o     (sig_clr),
        .cache_raddr_o (cache_raddr),
        .acc_clr_o     (acc_clr),
        .acc_add_o     (acc_add),
        .acc_val_o     (acc_val)
    );

    assign img_valid_o = sig_ok;

    AST_READ_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i && !mem_wr_o && (mem_addr_o != AW'(WORDS - 1)))
        |=> (!mem_req_o || mem_wr_o || (mem_addr_o == $past(mem_addr_o) + AW'(1)))); // R1

    AST_FAIL_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !pass_o) |-> (!img_valid_o && err_o)); // R3

    AST_WRITE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_wr_o && mem_ack_i) |=> !img_valid_o); // R10

    AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !load_i && !upd_i && lkp_req_i && (lkp_idx_i >= IW'(WORDS)))
        |=> (lkp_vld_o && (lkp_word_o == '0) && !busy_o)); // R8

    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_vld_o && !img_valid_o) |-> (lkp_word_o == '0)); // R7

endmodule

// File: tb/eeprom_image_loader_tb.sv
`timescale 1ns/1ps
module eeprom_image_loader_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_i, upd_i, lkp_req_i;
    logic [6:0]  lkp_idx_i;
    logic        lkp_vld_o;
    logic [15:0] lkp_word_o;
    logic        img_valid_o, err_o, busy_o, done_o, pass_o;
    logic        mem_req_o, mem_wr_o;
    logic [5:0]  mem_addr_o;
    logic [15:0] mem_wdata_o;
    logic        mem_ack_i;
    logic [15:0] mem_rdata_i;

    logic [15:0] mem [64];
    int          n_chk = 0;
    int          n_bad = 0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          seq_err = 0;
    int          lvld_seen = 0;
    logic [15:0] wr_val;
    logic [5:0]  wr_addr;

    always #4 clk = ~clk;

    eeprom_image_loader u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .upd_i       (upd_i),
        .lkp_req_i   (lkp_req_i),
        .lkp_idx_i   (lkp_idx_i),
        .lkp_vld_o   (lkp_vld_o),
        .lkp_word_o  (lkp_word_o),
        .img_valid_o (img_valid_o),
        .err_o       (err_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .pass_o      (pass_o),
        .mem_req_o   (mem_req_o),
        .mem_wr_o    (mem_wr_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_ack_i   (mem_ack_i),
        .mem_rdata_i (mem_rdata_i)
    );

    // EEPROM master model: acknowledges every other cycle while requested
    initial begin
        mem_ack_i   = 1'b0;
        mem_rdata_i = '0;
        forever begin
            @(posedge clk);
            if (mem_req_o && mem_ack_i) begin
                if (mem_wr_o) begin
                    mem[mem_addr_o] <= mem_wdata_o;
                    wr_cnt  = wr_cnt + 1;
                    wr_val  = mem_wdata_o;
                    wr_addr = mem_addr_o;
                end else begin
                    if (mem_addr_o != 6'(rd_cnt % 64)) seq_err = seq_err + 1;
                    rd_cnt = rd_cnt + 1;
                end
            end
            mem_ack_i   <= mem_req_o && !mem_ack_i;
            mem_rdata_i <= mem[mem_addr_o];
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (lkp_vld_o) lvld_seen = lvld_seen + 1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad = n_bad + 1;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sum_upto(input int n);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = s + mem[i];
        return s;
    endfunction

    function automatic logic exp_pass();
        return (sum_upto(64) == 16'hBABA) && (mem[10][15:14] == 2'b01);
    endfunction

    task automatic build_img(input int seed, input logic [1:0] sig, input logic good);
        for (int i = 0; i < 63; i++) begin
            mem[i] = 16'((seed * 40503 + i * 9973) ^ (i << 7) ^ (seed << 3));
        end
        mem[10][15:14] = sig;
        mem[63] = 16'hBABA - sum_upto(63) + (good ? 16'h0 : 16'h1);
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done_o && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk("R5 done reached", 32'(done_o), 32'd1);
    endtask

    task automatic do_load(input string tag);
        logic ep;
        ep = exp_pass();
        rd_cnt = 0; seq_err = 0;
        @(negedge clk); load_i = 1'b1;
        @(negedge clk); load_i = 1'b0;
        chk("R5 busy during load", 32'(busy_o), 32'd1);
        wait_done();
        chk("R5 busy low with done", 32'(busy_o), 32'd0);
        chk({tag, " pass"}, 32'(pass_o), 32'(ep));
        chk({tag, " err"}, 32'(err_o), 32'(!ep));
        chk({tag, " valid"}, 32'(img_valid_o), 32'(ep));
        chk("R1 read count", 32'(rd_cnt), 32'd64);
        chk("R1 ascending", 32'(seq_err), 32'd0);
    endtask

    task automatic lookup_fast(input string tag, input logic [6:0] idx, input logic [15:0] exp);
        int r0;
        r0 = rd_cnt;
        @(negedge clk); lkp_req_i = 1'b1; lkp_idx_i = idx;
        @(negedge clk); lkp_req_i = 1'b0;
        chk({tag, " vld"}, 32'(lkp_vld_o), 32'd1);
        chk({tag, " word"}, 32'(lkp_word_o), 32'(exp));
        @(negedge clk);
        chk({tag, " no traffic"}, 32'(rd_cnt - r0 + int'(busy_o)), 32'd0);
    endtask

    task automatic lookup_load(input string tag, input logic [6:0] idx);
        logic ep;
        int t = 0;
        ep = exp_pass();
        rd_cnt = 0; seq_err = 0;
        @(negedge clk); lkp_req_i = 1'b1; lkp_idx_i = idx;
        @(negedge clk); lkp_req_i = 1'b0;
        chk({tag, " busy"}, 32'(busy_o), 32'd1);
        while (!lkp_vld_o && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk({tag, " vld"}, 32'(lkp_vld_o), 32'd1);
        chk({tag, " done same cycle"}, 32'(done_o), 32'd1);
        chk({tag, " word"}, 32'(lkp_word_o), ep ? 32'(mem[idx[5:0]]) : 32'd0);
        chk({tag, " reads"}, 32'(rd_cnt), 32'd64);
    endtask

    initial begin
        logic [15:0] exp_ck;
        int          lv0;
        rst_n = 1'b0; load_i = 1'b0; upd_i = 1'b0; lkp_req_i = 1'b0; lkp_idx_i = '0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 reset state
        chk("R5 reset busy", 32'(busy_o), 32'd0);
        chk("R5 reset done", 32'(done_o), 32'd0);
        chk("R5 reset valid", 32'(img_valid_o), 32'd0);
        chk("R5 reset err", 32'(err_o), 32'd0);
        chk("R5 reset req", 32'(mem_req_o), 32'd0);
        chk("R5 reset lkp", 32'(lkp_vld_o), 32'd0);

        // R8 out of range with invalid image
        lookup_fast("R8 idx64", 7'd64, 16'h0);
        lookup_fast("R8 idx127", 7'd127, 16'h0);

        // R1 R2 good image
        build_img(1, 2'b01, 1'b1);
        do_load("R2 good");

        // R6 sweep every index from the cache
        for (int i = 0; i < 64; i++) lookup_fast("R6 cached", 7'(i), mem[i]);
        lookup_fast("R8 idx100 valid", 7'd100, 16'h0);

        // R11 strobes while busy are ignored
        lv0 = lvld_seen;
        rd_cnt = 0;
        @(negedge clk); load_i = 1'b1;
        @(negedge clk); load_i = 1'b0; upd_i = 1'b1;
        @(negedge clk); upd_i = 1'b0; lkp_req_i = 1'b1; lkp_idx_i = 7'd5;
        @(negedge clk); lkp_req_i = 1'b0;
        wait_done();
        repeat (4) @(negedge clk);
        chk("R11 no write while busy", 32'(wr_cnt), 32'd0);
        chk("R11 no lookup while busy", 32'(lvld_seen - lv0), 32'd0);
        chk("R11 single load", 32'(rd_cnt), 32'd64);
        chk("R11 idle after", 32'(busy_o), 32'd0);

        // R11 priority load over update
        rd_cnt = 0;
        @(negedge clk); load_i = 1'b1; upd_i = 1'b1;
        @(negedge clk); load_i = 1'b0; upd_i = 1'b0;
        wait_done();
        chk("R11 load wins", 32'(wr_cnt), 32'd0);
        chk("R11 load wins reads", 32'(rd_cnt), 32'd64);

        // R9 R10 checksum update
        mem[7] = mem[7] ^ 16'h0F0F;
        exp_ck = 16'hBABA - sum_upto(63);
        rd_cnt = 0; seq_err = 0;
        @(negedge clk); upd_i = 1'b1;
        @(negedge clk); upd_i = 1'b0;
        chk("R9 busy", 32'(busy_o), 32'd1);
        wait_done();
        chk("R9 pass", 32'(pass_o), 32'd1);
        chk("R9 reads", 32'(rd_cnt), 32'd63);
        chk("R9 read order", 32'(seq_err), 32'd0);
        chk("R9 one write", 32'(wr_cnt), 32'd1);
        chk("R9 write addr", 32'(wr_addr), 32'd63);
        chk("R9 write value", 32'(wr_val), 32'(exp_ck));
        chk("R10 invalid after write", 32'(img_valid_o), 32'd0);

        // R7 lookup triggers reload that now passes
        @(negedge clk);
        lookup_load("R7 reload pass", 7'd7);
        chk("R7 valid after", 32'(img_valid_o), 32'd1);

        // R3 checksum failure, then R7 reload that fails
        mem[20] = mem[20] + 16'h1;
        do_load("R3 bad sum");
        lookup_load("R7 reload fail", 7'd20);
        chk("R3 err kept", 32'(err_o), 32'd1);

        // R4 signature mismatches with good checksum
        build_img(3, 2'b10, 1'b1);
        do_load("R4 sig10");
        build_img(4, 2'b00, 1'b1);
        do_load("R4 sig00");
        build_img(5, 2'b11, 1'b1);
        do_load("R4 sig11");

        // R2 sweep of generated images
        for (int k = 0; k < 12; k++) begin
            build_img(k + 7, 2'(k % 4), (k % 3) != 0);
            do_load("R2 sweep");
            if (exp_pass()) lookup_fast("R6 sweep word63", 7'd63, mem[63]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule